// File: doc/BRIEF.md
# Biased Random Equivalence Checker

This block judges, by random simulation in hardware, whether two four-input combinational functions compute the same thing. The reference function is f = x1·x3·x4 + x2·x3 + x2·x4. The second function is either an identical copy or a faulty copy whose first product term also needs x2 (x1·x2·x3·x4). That fault removes exactly one minterm. Both functions see the same vector in every cycle, and their outputs are XORed. A 1 on the XOR marks a disagreement.

A start pulse begins a run. On the start edge every input lane latches a fresh probability of being 1. The probability comes from the lane's own free-running LFSR and is limited to the range [1/4, 3/4). After that, each cycle applies one vector in which every bit is 1 when a second slice of that lane's LFSR is below the lane's threshold. The run stops at the first disagreement, which gives an unequal verdict and keeps the offending vector. If no disagreement occurs, it stops after the programmed number of vectors and the verdict is "probably equal". The LFSRs restart from fixed nonzero seeds at reset. A run started a fixed number of cycles after reset is therefore fully reproducible. The ports carry plain control and status only: no data stream crosses the block edge, so there is no valid/ready handshake.

Top module: `rand_equiv_checker`

## Requirements
- R1: While rst_n is low and in the cycle after its release, busy, done, equal and fail_vec are all 0.
- R2: A start pulse seen while idle with a nonzero vec_limit raises busy at the next clock edge. A start seen while busy is ignored and does not change the length or result of the run in progress.
- R3: A start with vec_limit equal to 0 applies no vectors. done rises at the next edge with equal = 1, and busy stays 0.
- R4: With use_faulty = 0 (identical copy), done rises exactly vec_limit edges after the edge that accepted start, with equal = 1 and fail_vec = 0.
- R5: When the run ends on a disagreement, equal = 0 and fail_vec holds the vector that caused it. fail_vec bit 0 is x1, bit 1 is x2, bit 2 is x3 and bit 3 is x4, so the faulty copy can only fail with fail_vec = 4'hD.
- R6: A run never applies more than vec_limit vectors. The number of edges from the accepting edge to done is at most vec_limit.
- R7: If the last allowed vector is also the first disagreeing vector, the verdict is unequal (equal = 0, fail_vec = 4'hD).
- R8: done is a one-cycle pulse, and busy is 0 whenever done is 1.
- R9: use_faulty and vec_limit are sampled at the accepting edge. Each lane's probability is redrawn there within [1/4, 3/4). With use_faulty = 1, a run with vec_limit = 20000 therefore ends unequal.
- R10: equal and fail_vec change only at the edge where done rises, and they hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (acted on only while idle) |
| use_faulty | input | 1 | 1 selects the faulty copy as second function, 0 the identical copy |
| vec_limit | input | 16 | Maximum number of vectors in the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| equal | output | 1 | Verdict of the last run: 1 probably equal, 0 unequal |
| fail_vec | output | 4 | Vector that exposed the disagreement, 0 after an equal verdict |

## Verification
The two functions that can land in the same cycle are the vector-count limit and the mismatch detector: the last permitted vector may also be the first disagreeing one. To provoke this, the bench first finds the index k of the first disagreement for a given reset-to-start delay. It then repeats that run from reset with vec_limit = k and with vec_limit = k - 1. The first repeat must give an unequal verdict after exactly k vectors with fail_vec = 4'hD, and the second an equal verdict after k - 1 vectors. A second start pulse in the middle of the run must leave both results unchanged.

// File: rtl/eqc_pkg.sv
package eqc_pkg;
  localparam int N_IN = 4;

  typedef enum logic {ST_IDLE, ST_RUN} eqc_state_e;

  // bit 0 = x1, bit 1 = x2, bit 2 = x3, bit 3 = x4
  function automatic logic golden_fn(input logic [N_IN-1:0] v);
    return (v[0] & v[2] & v[3]) | (v[1] & v[2]) | (v[1] & v[3]);
  endfunction

  function automatic logic faulty_fn(input logic [N_IN-1:0] v);
    return (v[0] & v[1] & v[2] & v[3]) | (v[1] & v[2]) | (v[1] & v[3]);
  endfunction
endpackage

// File: rtl/eqc_lfsr.sv
module eqc_lfsr #(
  parameter int          WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'h0001
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] state
);
  // Galois form, shifting right; the tap mask is applied when bit 0 leaves
  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED;
    else if (state[0]) state <= (state >> 1) ^ TAPS;
    else state <= state >> 1;
  end
endmodule

// File: rtl/eqc_bias_lane.sv
module eqc_bias_lane #(
  parameter int               LFSR_W = 16,
  parameter int               PROB_W = 8,
  parameter logic [LFSR_W-1:0] SEED  = 16'h0001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic draw,
  output logic bit_out
);
  localparam logic [PROB_W-1:0] QUARTER = PROB_W'(1) << (PROB_W - 2);

  logic [LFSR_W-1:0] rnd;
  logic [PROB_W-1:0] thr;
  logic [PROB_W-1:0] thr_src;
  logic [PROB_W-1:0] sample;

  eqc_lfsr #(.WIDTH(LFSR_W), .TAPS(16'hB400), .SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (rnd)
  );

  assign thr_src = rnd[PROB_W-1:0];
  assign sample  = rnd[LFSR_W-1 -: PROB_W];

  // probability drawn into [1/4, 3/4)
  always_ff @(posedge clk) begin
    if (!rst_n) thr <= QUARTER;
    else if (draw) thr <= QUARTER + (thr_src >> 1);
  end

  assign bit_out = (sample < thr);
endmodule

// File: rtl/eqc_fn_pair.sv
module eqc_fn_pair
  import eqc_pkg::*;
(
  input  logic [N_IN-1:0] vec,
  input  logic            sel_faulty,
  output logic            differ
);
  logic out_ref;
  logic out_alt;

  always_comb begin
    out_ref = golden_fn(vec);
    out_alt = sel_faulty ? faulty_fn(vec) : golden_fn(vec);
    differ  = out_ref ^ out_alt;
  end
endmodule

// File: rtl/eqc_ctrl.sv
module eqc_ctrl
  import eqc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_faulty,
  input  logic [CNT_W-1:0] vec_limit,
  input  logic [N_IN-1:0]  vec,
  input  logic             differ,
  output logic             draw,
  output logic             mode_q,
  output logic [CNT_W-1:0] lim_q,
  output logic             busy,
  output logic             done,
  output logic             equal,
  output logic [N_IN-1:0]  fail_vec
);
  eqc_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic             last_vec;

  assign draw     = start && (st == ST_IDLE);
  assign cnt_nx   = cnt + CNT_W'(1);
  assign last_vec = (cnt_nx == lim_q);
  assign busy     = (st == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      lim_q    <= '0;
      mode_q   <= 1'b0;
      done     <= 1'b0;
      equal    <= 1'b0;
      fail_vec <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            lim_q  <= vec_limit;
            mode_q <= use_faulty;
            cnt    <= '0;
            if (vec_limit == '0) begin
              done     <= 1'b1;
              equal    <= 1'b1;
              fail_vec <= '0;
            end else begin
              st <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          cnt <= cnt_nx;
          if (differ) begin
            st       <= ST_IDLE;
            done     <= 1'b1;
            equal    <= 1'b0;
            fail_vec <= vec;
          end else if (last_vec) begin
            st       <= ST_IDLE;
            done     <= 1'b1;
            equal    <= 1'b1;
            fail_vec <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rand_equiv_checker.sv
module rand_equiv_checker
  import eqc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PROB_W = 8,
  parameter int LFSR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_faulty,
  input  logic [CNT_W-1:0] vec_limit,
  output logic             busy,
  output logic             done,
  output logic             equal,
  output logic [N_IN-1:0]  fail_vec
);
  logic [N_IN-1:0]  vec;
  logic             differ;
  logic             draw;
  logic             mode_q;
  logic [CNT_W-1:0] lim_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    eqc_bias_lane #(
      .LFSR_W (LFSR_W),
      .PROB_W (PROB_W),
      .SEED   (LFSR_W'(16'h1D35 + 16'h2F4B * (i + 1)))
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .draw    (draw),
      .bit_out (vec[i])
    );
  end

  eqc_fn_pair u_pair (
    .vec        (vec),
    .sel_faulty (mode_q),
    .differ     (differ)
  );

  eqc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .use_faulty (use_faulty),
    .vec_limit  (vec_limit),
    .vec        (vec),
    .differ     (differ),
    .draw       (draw),
    .mode_q     (mode_q),
    .lim_q      (lim_q),
    .busy       (busy),
    .done       (done),
    .equal      (equal),
    .fail_vec   (fail_vec)
  );
endmodule

// File: rtl/eqc_checker.sv
module eqc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             equal,
  input logic [3:0]       fail_vec,
  input logic             mode_q,
  input logic [CNT_W-1:0] lim_q
);
  logic [CNT_W:0] busy_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_cyc <= '0;
    else if (busy) busy_cyc <= busy_cyc + 1'b1;
    else busy_cyc <= '0;
  end

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_same_copy_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> equal);

  assert_fail_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !equal) |-> (fail_vec == 4'hD));

  assert_vec_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cyc <= {1'b0, lim_q}));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(equal) && $stable(fail_vec)));
endmodule

bind rand_equiv_checker eqc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .equal    (equal),
  .fail_vec (fail_vec),
  .mode_q   (mode_q),
  .lim_q    (lim_q)
);

// File: tb/tb_rand_equiv_checker.sv
module tb_rand_equiv_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        use_faulty = 1'b0;
  logic [15:0] vec_limit = '0;
  logic        busy, done, equal;
  logic [3:0]  fail_vec;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit timed_out = 0;

  rand_equiv_checker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .use_faulty(use_faulty),
    .vec_limit(vec_limit), .busy(busy), .done(done), .equal(equal),
    .fail_vec(fail_vec)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int idle_after);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (idle_after) @(negedge clk);
  endtask

  // runs one job; k = edges from the accepting edge to done
  task automatic run(input int lim, input bit faulty, input int restart_at,
                     output int k, output int eq, output int fv);
    use_faulty = faulty;
    vec_limit  = 16'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 70000) begin
      @(negedge clk);
      k++;
      if (k == restart_at) start = 1'b1;
      else start = 1'b0;
      if (k == 1 && lim > 0 && !done) check("R2 busy raised", int'(busy), 1);
    end
    start = 1'b0;
    if (!done) begin
      timed_out = 1;
      check("R6 run ended", 0, 1);
    end
    eq = int'(equal);
    fv = int'(fail_vec);
    check("R8 busy low at done", int'(busy), 0);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    int k, eq, fv;
    int kfirst [8];

    do_reset(0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 equal", int'(equal), 0);
    check("R1 fail_vec", int'(fail_vec), 0);

    // R3: zero vectors
    for (int m = 0; m < 2; m++) begin
      run(0, bit'(m), -1, k, eq, fv);
      check("R3 count", k, 0);
      check("R3 equal", eq, 1);
    end

    // R4: identical copy sweep
    for (int lim = 1; lim <= 40; lim++) begin
      run(lim, 1'b0, -1, k, eq, fv);
      check("R4 count", k, lim);
      check("R4 equal", eq, 1);
      check("R4 fail_vec", fv, 0);
    end
    run(5000, 1'b0, -1, k, eq, fv);
    check("R4 long count", k, 5000);
    check("R4 long equal", eq, 1);

    // R5 R6 R9: faulty copy across start delays
    for (int d = 0; d < 8; d++) begin
      do_reset(d);
      run(20000, 1'b1, -1, k, eq, fv);
      kfirst[d] = k;
      check("R9 unequal", eq, 0);
      check("R5 fail_vec", fv, 4'hD);
      check("R6 within budget", int'(k <= 20000 && k >= 1), 1);
      repeat (5) @(negedge clk);
      check("R10 equal held", int'(equal), 0);
      check("R10 fail_vec held", int'(fail_vec), 4'hD);
    end

    // R7: limit reached on the first disagreeing vector; R2 restart ignored
    for (int d = 0; d < 8; d++) begin
      do_reset(d);
      run(kfirst[d], 1'b1, -1, k, eq, fv);
      check("R7 count", k, kfirst[d]);
      check("R7 unequal", eq, 0);
      check("R7 fail_vec", fv, 4'hD);
      if (kfirst[d] > 1) begin
        do_reset(d);
        run(kfirst[d] - 1, 1'b1, -1, k, eq, fv);
        check("R7 one short count", k, kfirst[d] - 1);
        check("R7 one short equal", eq, 1);
        do_reset(d);
        run(kfirst[d], 1'b1, (kfirst[d] + 1) / 2, k, eq, fv);
        check("R2 restart ignored count", k, kfirst[d]);
        check("R2 restart ignored verdict", eq, 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule